// File: doc/BRIEF.md
# Protocol Timeout Timer with Bus-Reset Re-Arm

This block is a reloading interval timer that higher-level protocol software uses to time out transactions. It counts down in milliseconds. The millisecond step comes from an incoming prescale tick divided by a parameter, so simulations can run with short periods. A period select picks the long period (1 s by default) or the short period (100 ms by default). A run bit starts and stops the count. Each expiry produces a one-cycle event and sets a sticky status bit. That bit feeds the timer flag in the link layer's interrupt register, and the host clears it by writing a one.

The block has two modes. In normal mode the timer fires on every expiry, reloads itself and keeps going for as long as the run bit stays set. In bus-reset mode, every bus-reset pulse loads the long period and starts the count. This happens even when the timer is already counting and even when the run bit is clear. The timer fires only once a full long period passes with no further bus reset, and it then idles until the next bus reset arrives.

Top module: `proto_timer`

## Requirements
- R1: After reset, timerArmed is 0, msRemaining is 0, expireEvt is 0 and timerStatus is 0.
- R2: While armed and counting, msRemaining falls by exactly one after every TICKS_PER_MS cycles in which tickIn is 1. Cycles in which tickIn is 0 do not advance the prescaler.
- R3: A 0-to-1 change of runBit loads msRemaining with LONG_MS when longSel is 1, or with SHORT_MS when longSel is 0. It also sets timerArmed and restarts the prescaler, so the first step comes TICKS_PER_MS ticks later.
- R4: In normal mode (modeBit 0), the tick that would take msRemaining from 1 to 0 instead reloads the period chosen by the current longSel. The timer stays armed, and expireEvt is 1 for the following cycle.
- R5: When runBit is 0 in normal mode, or in the cycle where runBit falls in either mode, counting stops at once. timerArmed drops and msRemaining holds its value, whatever tickIn does.
- R6: In bus-reset mode (modeBit 1), a busReset pulse loads LONG_MS, restarts the prescaler and sets timerArmed. This holds when runBit is 0 and when the timer is already counting.
- R7: In bus-reset mode, the tick that ends the period makes expireEvt 1 for one cycle. msRemaining becomes 0 and timerArmed becomes 0, and they stay there until the next load.
- R8: In normal mode a busReset pulse has no effect on msRemaining, timerArmed or expireEvt.
- R9: timerStatus is set by every expiry. It stays set until statusClr is 1 in a cycle with no expiry. An expiry in the same cycle as statusClr leaves it set.
- R10: In bus-reset mode, a busReset in the same cycle as the final tick wins. No expiry occurs, and msRemaining reloads to LONG_MS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Prescale tick, divided by TICKS_PER_MS into milliseconds |
| runBit | input | 1 | Run/stop control level |
| modeBit | input | 1 | 0 = normal reload mode, 1 = bus-reset mode |
| longSel | input | 1 | 1 = LONG_MS period, 0 = SHORT_MS period |
| busReset | input | 1 | One-cycle bus-reset event |
| statusClr | input | 1 | Write-one-to-clear for timerStatus |
| expireEvt | output | 1 | One-cycle expiry event |
| timerStatus | output | 1 | Sticky expiry status bit |
| timerArmed | output | 1 | Timer is counting |
| msRemaining | output | CNT_W | Milliseconds left in the current period |

## Verification
The normal mode is run three ways: with an unbroken tick, with a tick that skips every third cycle, and with the long period. These separate the prescaler from the period counter and show which period select a reload uses. Stopping and restarting in the middle of a period, with ticks still arriving while stopped, tells holding apart from resetting. In bus-reset mode the bench sends a bus reset while the run bit is clear, then another in the middle of a period, then one aimed at the exact final tick, and it also lets a quiet period run out. These cases separate re-arming from expiry and show the timer idling after it fires. The status clear is held over an expiry to show that setting wins over clearing.

// File: rtl/proto_timer_pkg.sv
package proto_timer_pkg;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic loadLong;    // load the long period, restart prescaler
    logic loadShort;   // load the short period, restart prescaler
    logic countEn;     // prescaler and counter may advance
    logic autoReload;  // on final tick reload instead of stopping at zero
    logic reloadLong;  // period used by an automatic reload
  } tmrCmd_t;

endpackage

// File: rtl/proto_timer_dp.sv
module proto_timer_dp
  import proto_timer_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int LONG_MS      = 1000,
  parameter int SHORT_MS     = 100,
  parameter int CNT_W        = $clog2(LONG_MS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickIn,
  input  tmrCmd_t          cmd,
  output logic             finalTick,
  output logic [CNT_W-1:0] msCount
);

  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [CNT_W-1:0] LONG_VAL  = CNT_W'(LONG_MS);
  localparam logic [CNT_W-1:0] SHORT_VAL = CNT_W'(SHORT_MS);

  logic anyLoad;
  logic preWrap;
  logic msTick;

  assign anyLoad = cmd.loadLong | cmd.loadShort;

  generate
    if (TICKS_PER_MS > 1) begin : g_prescale
      logic [PRE_W-1:0] preCnt;
      assign preWrap = (preCnt == PRE_W'(TICKS_PER_MS - 1));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          preCnt <= '0;
        end else if (anyLoad) begin
          preCnt <= '0;
        end else if (cmd.countEn && tickIn) begin
          preCnt <= preWrap ? '0 : preCnt + 1'b1;
        end
      end
    end else begin : g_direct
      assign preWrap = 1'b1;
    end
  endgenerate

  assign msTick    = cmd.countEn & tickIn & preWrap & ~anyLoad;
  assign finalTick = msTick & (msCount == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msCount <= '0;
    end else if (anyLoad) begin
      msCount <= cmd.loadLong ? LONG_VAL : SHORT_VAL;
    end else if (finalTick) begin
      if (cmd.autoReload) msCount <= cmd.reloadLong ? LONG_VAL : SHORT_VAL;
      else                msCount <= '0;
    end else if (msTick && msCount != '0) begin
      msCount <= msCount - 1'b1;
    end
  end

  // R5: with no enable and no load the count holds
  assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.countEn && !anyLoad) |=> $stable(msCount));

  // R2: the count never exceeds the long period
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msCount <= LONG_VAL);

  // R7: a final tick without auto reload leaves zero
  assert_zero_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finalTick && !cmd.autoReload) |=> (msCount == '0));

endmodule

// File: rtl/proto_timer_ctrl.sv
module proto_timer_ctrl
  import proto_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    runBit,
  input  logic    modeBit,
  input  logic    longSel,
  input  logic    busReset,
  input  logic    statusClr,
  input  logic    finalTick,
  output tmrCmd_t cmd,
  output logic    armed,
  output logic    expirePulse,
  output logic    status
);

  logic runPrev;
  logic runRise;
  logic runFall;
  logic busLoad;

  assign runRise = runBit & ~runPrev;
  assign runFall = ~runBit & runPrev;
  assign busLoad = modeBit & busReset;

  always_comb begin
    cmd.loadLong   = busLoad | (runRise & longSel);
    cmd.loadShort  = runRise & ~longSel & ~busLoad;
    cmd.countEn    = armed & (runBit | (modeBit & ~runFall));
    cmd.autoReload = ~modeBit;
    cmd.reloadLong = longSel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runPrev     <= 1'b0;
      armed       <= 1'b0;
      expirePulse <= 1'b0;
      status      <= 1'b0;
    end else begin
      runPrev     <= runBit;
      expirePulse <= finalTick;
      status      <= finalTick | (status & ~statusClr);
      if (cmd.loadLong || cmd.loadShort)      armed <= 1'b1;
      else if (runFall)                       armed <= 1'b0;
      else if (!modeBit && !runBit)           armed <= 1'b0;
      else if (finalTick && modeBit)          armed <= 1'b0;
    end
  end

  // R9: status holds unless cleared
  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !statusClr) |=> status);

  // R9: an expiry event is always reflected in status
  assert_status_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expirePulse |-> status);

  // R6: a bus reset in bus-reset mode arms the timer
  assert_busreset_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBit && busReset) |=> armed);

  // R7: expiry in bus-reset mode leaves the timer idle
  assert_idle_after_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finalTick && modeBit) |=> !armed);

  // R8: a bus reset in normal mode cannot start a stopped timer
  assert_busreset_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeBit && !armed && busReset && !runRise) |=> !armed);

endmodule

// File: rtl/proto_timer.sv
module proto_timer
  import proto_timer_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int LONG_MS      = 1000,
  parameter int SHORT_MS     = 100,
  parameter int CNT_W        = $clog2(LONG_MS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickIn,
  input  logic             runBit,
  input  logic             modeBit,
  input  logic             longSel,
  input  logic             busReset,
  input  logic             statusClr,
  output logic             expireEvt,
  output logic             timerStatus,
  output logic             timerArmed,
  output logic [CNT_W-1:0] msRemaining
);

  tmrCmd_t cmd;
  logic    finalTick;

  proto_timer_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .runBit      (runBit),
    .modeBit     (modeBit),
    .longSel     (longSel),
    .busReset    (busReset),
    .statusClr   (statusClr),
    .finalTick   (finalTick),
    .cmd         (cmd),
    .armed       (timerArmed),
    .expirePulse (expireEvt),
    .status      (timerStatus)
  );

  proto_timer_dp #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .LONG_MS      (LONG_MS),
    .SHORT_MS     (SHORT_MS),
    .CNT_W        (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tickIn    (tickIn),
    .cmd       (cmd),
    .finalTick (finalTick),
    .msCount   (msRemaining)
  );

endmodule

// File: tb/proto_timer_bench.sv
module proto_timer_bench;

  localparam int TPM   = 3;
  localparam int LMS   = 20;
  localparam int SMS   = 6;
  localparam int CW    = $clog2(LMS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickIn = 1'b0, runBit = 1'b0, modeBit = 1'b0, longSel = 1'b0;
  logic busReset = 1'b0, statusClr = 1'b0;
  logic expireEvt, timerStatus, timerArmed;
  logic [CW-1:0] msRemaining;

  always #2 clk = ~clk;

  proto_timer #(.TICKS_PER_MS(TPM), .LONG_MS(LMS), .SHORT_MS(SMS)) u_proto_timer (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .runBit(runBit), .modeBit(modeBit),
    .longSel(longSel), .busReset(busReset), .statusClr(statusClr),
    .expireEvt(expireEvt), .timerStatus(timerStatus), .timerArmed(timerArmed),
    .msRemaining(msRemaining)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string reqTag = "R1";
  int expiries = 0;

  // behavioural reference state
  int mCnt = 0, mPre = 0;
  bit mArmed = 0, mExp = 0, mStat = 0, mRunPrev = 0;

  task automatic modelStep();
    bit rise = runBit && !mRunPrev;
    bit fall = !runBit && mRunPrev;
    bit bl = modeBit && busReset;
    bit en = mArmed && (runBit || (modeBit && !fall));
    bit nExp = 0;
    if (bl || rise) begin
      mCnt = (bl || longSel) ? LMS : SMS;
      mPre = 0;
      mArmed = 1;
    end else begin
      if (en && tickIn) begin
        if (mPre == TPM - 1) begin
          mPre = 0;
          if (mCnt == 1) begin
            nExp = 1;
            if (modeBit) begin mCnt = 0; mArmed = 0; end
            else mCnt = longSel ? LMS : SMS;
          end else if (mCnt > 0) mCnt--;
        end else mPre++;
      end
      if (fall || (!modeBit && !runBit)) mArmed = 0;
    end
    mStat = nExp || (mStat && !statusClr);
    mExp = nExp;
    mRunPrev = runBit;
  endtask

  task automatic compare();
    compared++;
    if (expireEvt !== mExp || timerStatus !== mStat || timerArmed !== mArmed ||
        msRemaining !== CW'(mCnt)) begin
      mismatched++;
      $display("FAIL %s t=%0t: exp/stat/armed/cnt actual %b/%b/%b/%0d expected %b/%b/%b/%0d",
               reqTag, $time, expireEvt, timerStatus, timerArmed, msRemaining,
               mExp, mStat, mArmed, mCnt);
    end
    if (mExp) expiries++;
  endtask

  task automatic cyc();
    modelStep();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reqTag = "R1";
    compare();
    run(2);

    // R3 / R2 / R4: short period, unbroken tick, normal mode
    reqTag = "R3"; tickIn = 1; longSel = 0; runBit = 1;
    run(4);
    reqTag = "R4";
    run(50);

    // R2: irregular tick
    reqTag = "R2";
    for (int i = 0; i < 60; i++) begin
      tickIn = (i % 3 != 0);
      cyc();
    end
    tickIn = 1;

    // R5: stop mid period, ticks keep arriving
    reqTag = "R5"; runBit = 0;
    run(12);
    // R8: bus reset in normal mode while stopped and while running
    reqTag = "R8"; busReset = 1; cyc(); busReset = 0; run(3);

    // R3 / R4: long period restart
    reqTag = "R3"; longSel = 1; runBit = 1;
    run(10);
    reqTag = "R8"; busReset = 1; cyc(); busReset = 0;
    reqTag = "R4";
    run(120);

    // R9: clear held across an expiry, then a plain clear
    reqTag = "R9"; statusClr = 1;
    run(70);
    statusClr = 0; run(3);
    statusClr = 1; cyc(); statusClr = 0; run(3);

    // R6: bus-reset mode with run clear
    runBit = 0; run(2);
    modeBit = 1; longSel = 0;
    reqTag = "R6"; busReset = 1; cyc(); busReset = 0;
    run(25);
    busReset = 1; cyc(); busReset = 0;   // re-arm mid count
    run(25);
    // R7: quiet period runs out, then idle
    reqTag = "R7";
    run(60);

    // R10: bus reset exactly on the final tick
    reqTag = "R6"; busReset = 1; cyc(); busReset = 0;
    reqTag = "R10";
    for (int i = 0; i < 200; i++) begin
      if (mArmed && mCnt == 1 && mPre == TPM - 1) break;
      cyc();
    end
    busReset = 1; cyc(); busReset = 0;
    if (mExp || mCnt != LMS) begin
      mismatched++;
      $display("FAIL R10 bench did not reach final tick: cnt %0d expected %0d", mCnt, LMS);
    end
    reqTag = "R7";
    run(70);

    // R5: run falling edge stops bus-reset mode counting
    reqTag = "R5"; runBit = 1; cyc(); run(5); runBit = 0; run(10);

    if (expiries < 6) begin
      mismatched++;
      $display("FAIL R4 too few expiries seen: actual %0d expected >= 6", expiries);
    end
    finished = 1;
    summary();
  end

endmodule